// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator with Single-Shot and Free-Running Modes

This block converts the one-bit output of a delta-sigma modulator into signed 24-bit words. Four cascaded accumulators run at the sample rate. Four differencing stages run once every R accepted samples, where R = 2^LOG2R. Together they give a sinc^4 response with 4R-3 taps. Each accepted bit stands for +1 when high and -1 when low. The wide filter result is shifted so that the ideal full-scale value R^4 lands on 2^23, then clipped into the 24-bit two's complement range.

Two operating modes exist. In the single-shot mode a start pulse clears the filter and begins a conversion. After four whole decimation periods of accepted samples the block emits exactly one word. It then clears itself again and ignores further samples until the next start. In the free-running mode the filter is never cleared. It emits a word once every R accepted samples, but it holds back the first three words after a clear because they are not yet settled. Changing the mode input also clears the filter and restarts the settling count.

The bitstream enters through a sample strobe that has no back-pressure, because a modulator cannot be stalled. The result leaves as a one-cycle valid pulse with no ready input. A downstream consumer must take the word in the cycle its strobe is high, although the word stays on the data port until the next strobe.

Top module: `sinc4_decim`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 24'h000000.
- R2: A bit value of 1 counts as +1 and a bit value of 0 counts as -1. A settled run of ones gives 24'h7FFFFF, because the positive full scale R^4 is clipped. A settled run of zeros gives 24'h800000.
- R3: A settled input that alternates 1,0,1,0 gives 24'h000000.
- R4: Each emitted word is y scaled by 2^(23-4*LOG2R) (an arithmetic right shift when 4*LOG2R exceeds 23) and then clipped to [-2^23, 2^23-1]. Here y is the sinc^4 sum of the accepted samples since the last clear, using 4R-3 taps, with samples older than the clear counting as 0.
- R5: In single-shot mode (mode_cont = 0), out_valid pulses exactly once per start. It is high in the cycle after the cycle that carries the 4R-th accepted sample counted from the start. A sample strobed in the start cycle is the first sample.
- R6: In single-shot mode, after a result has been emitted or before any start, strobed samples are ignored. No out_valid appears and out_data is unchanged until a new start.
- R7: In free-running mode (mode_cont = 1), out_valid pulses one cycle after every R-th accepted sample. The first three such points after a clear are suppressed, so the first word follows the 4R-th sample. out_valid is never high in two consecutive cycles.
- R8: In free-running mode, start has no effect and the output stream continues as if no pulse had arrived.
- R9: In single-shot mode, a start during a conversion clears the filter and restarts the count. This also applies when the start falls in the same cycle as the sample that would have completed the conversion: that result is dropped, and the sample counts as the first of the new conversion.
- R10: A change of mode_cont clears the filter in that cycle. On a change to free-running mode, a sample in that cycle is the first sample.
- R11: out_data changes only in cycles where out_valid is high.
- R12: Cycles with bit_valid low have no effect on the filter or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cont | input | 1 | 1 = free-running, 0 = single-shot |
| start | input | 1 | Single-shot conversion start pulse |
| bit_valid | input | 1 | Sample strobe for bit_in |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| out_data | output | 24 | Signed result word |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
The interesting collision is a start pulse landing in the same cycle as the sample that would finish a single-shot conversion, and a start arriving together with any sample. The bench provokes the first directly by feeding 4R-1 samples and then strobing the last sample with start high. It judges the outcome cycle by cycle: no strobe may appear in that cycle, and the next word must follow exactly 4R accepted samples later and hold the sinc^4 sum of only the new samples. Random start pulses in free-running mode check that the same coincidence there leaves the word stream untouched.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
  localparam int unsigned ORDER = 4;
  localparam int unsigned OUT_W = 24;

  // sign bit plus one guard bit so that +R^4 does not wrap
  function automatic int unsigned acc_width(input int unsigned log2r);
    return ORDER * log2r + 2;
  endfunction
endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
  import sinc4_pkg::*;
#(
  parameter int LOG2R = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_cont,
  input  logic start,
  input  logic bit_valid,
  output logic clr_pre,
  output logic clr_post,
  output logic take,
  output logic tick,
  output logic emit
);
  localparam logic [LOG2R-1:0] LAST = '1;
  localparam logic [1:0] SETTLED = 2'd3;

  logic             mode_q;
  logic             active_q;
  logic [LOG2R-1:0] cnt_q;
  logic [1:0]       dec_q;
  logic             restart;
  logic             run_now;
  logic [LOG2R-1:0] cnt_base;
  logic [1:0]       dec_base;
  logic             active_base;

  always_comb begin
    restart     = (mode_cont != mode_q) || (!mode_cont && start);
    clr_pre     = restart;
    active_base = restart ? start : active_q;
    run_now     = mode_cont || active_base;
    take        = bit_valid && run_now;
    cnt_base    = restart ? '0 : cnt_q;
    dec_base    = restart ? '0 : dec_q;
    tick        = take && (cnt_base == LAST);
    emit        = tick && (dec_base == SETTLED);
    clr_post    = emit && !mode_cont;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      dec_q    <= '0;
    end else begin
      mode_q <= mode_cont;
      if (clr_post) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        dec_q    <= '0;
      end else begin
        active_q <= !mode_cont && active_base;
        cnt_q    <= take ? cnt_base + 1'b1 : cnt_base;
        dec_q    <= (tick && dec_base != SETTLED) ? dec_base + 1'b1 : dec_base;
      end
    end
  end

  AST_EMIT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (!clr_pre && dec_q == SETTLED && cnt_q == LAST)); // R7
  AST_SINGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !mode_cont) |=> (!active_q && dec_q == 2'd0)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cont && !mode_q && !start && !active_q) |-> !take); // R6
endmodule

// File: rtl/sinc4_integ.sv
module sinc4_integ
  import sinc4_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_pre,
  input  logic         clr_post,
  input  logic         take,
  input  logic         bit_in,
  output logic [W-1:0] sum_next
);
  logic [ORDER:0][W-1:0] chain;

  // +1 for a high bit, -1 for a low bit, zero when no sample this cycle
  assign chain[0] = take ? (bit_in ? W'(1) : {W{1'b1}}) : '0;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [W-1:0] acc_q;
    logic [W-1:0] base;
    assign base         = clr_pre ? '0 : acc_q;
    assign chain[g + 1] = take ? base + chain[g] : base;

    always_ff @(posedge clk) begin
      if (!rst_n || clr_post) acc_q <= '0;
      else                    acc_q <= chain[g + 1];
    end
  end

  assign sum_next = chain[ORDER];
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb
  import sinc4_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_pre,
  input  logic         clr_post,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [ORDER:0][W-1:0] diff;

  assign diff[0] = din;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [W-1:0] dly_q;
    logic [W-1:0] prev;
    assign prev        = clr_pre ? '0 : dly_q;
    assign diff[g + 1] = diff[g] - prev;

    always_ff @(posedge clk) begin
      if (!rst_n || clr_post)   dly_q <= '0;
      else if (tick)            dly_q <= diff[g];
      else if (clr_pre)         dly_q <= '0;
    end
  end

  assign dout = diff[ORDER];
endmodule

// File: rtl/sinc4_scale.sv
module sinc4_scale
  import sinc4_pkg::*;
#(
  parameter int W     = 18,
  parameter int LOG2R = 4
) (
  input  logic [W-1:0]     din,
  output logic [OUT_W-1:0] dout
);
  localparam int MAG = ORDER * LOG2R;
  localparam int EW  = W + OUT_W;
  localparam logic signed [EW-1:0] MAXV = {{(EW - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {{(EW - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

  logic signed [EW-1:0] wide;
  logic signed [EW-1:0] shifted;

  assign wide = $signed({{OUT_W{din[W-1]}}, din});

  if (MAG <= OUT_W - 1) begin : g_up
    localparam int LSH = OUT_W - 1 - MAG;
    assign shifted = wide <<< LSH;
  end else begin : g_down
    localparam int RSH = MAG - (OUT_W - 1);
    assign shifted = wide >>> RSH;
  end

  always_comb begin
    if (shifted > MAXV)      dout = MAXV[OUT_W-1:0];
    else if (shifted < MINV) dout = MINV[OUT_W-1:0];
    else                     dout = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
  import sinc4_pkg::*;
#(
  parameter int LOG2R = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cont,
  input  logic             start,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid
);
  localparam int W = acc_width(LOG2R);

  logic             clr_pre;
  logic             clr_post;
  logic             take;
  logic             tick;
  logic             emit;
  logic [W-1:0]     integ_sum;
  logic [W-1:0]     comb_out;
  logic [OUT_W-1:0] scaled;

  sinc4_ctrl #(.LOG2R(LOG2R)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cont (mode_cont),
    .start     (start),
    .bit_valid (bit_valid),
    .clr_pre   (clr_pre),
    .clr_post  (clr_post),
    .take      (take),
    .tick      (tick),
    .emit      (emit)
  );

  sinc4_integ #(.W(W)) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_pre  (clr_pre),
    .clr_post (clr_post),
    .take     (take),
    .bit_in   (bit_in),
    .sum_next (integ_sum)
  );

  sinc4_comb #(.W(W)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_pre  (clr_pre),
    .clr_post (clr_post),
    .tick     (tick),
    .din      (integ_sum),
    .dout     (comb_out)
  );

  sinc4_scale #(.W(W), .LOG2R(LOG2R)) u_scale (
    .din  (comb_out),
    .dout (scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_data <= scaled;
    end
  end

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (comb_out == '0 || scaled == '0 || scaled[OUT_W-1] == comb_out[W-1])); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R11
endmodule

// File: tb/sinc4_decim_tb.sv
`timescale 1ns/1ps
module sinc4_decim_tb;
  localparam int LOG2R = 4;
  localparam int R     = 1 << LOG2R;
  localparam int NT    = 4 * R - 3;
  localparam int MAG   = 4 * LOG2R;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_cont = 1'b0;
  logic        start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [23:0] out_data;
  logic        out_valid;

  sinc4_decim #(.LOG2R(LOG2R)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cont (mode_cont),
    .start     (start),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  always #10 clk = ~clk;

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done = 1'b0;
  string  cur_tag = "R1";
  longint taps [NT];
  int     hist [NT];
  int     m_mode = 0;
  int     m_active = 0;
  int     m_cnt = 0;
  int     m_dec = 0;
  bit     exp_emit;
  logic [23:0] exp_val;
  logic [23:0] last_d = 24'h0;

  function automatic void build_taps();
    longint box [NT];
    longint acc [NT];
    for (int i = 0; i < NT; i++) begin
      box[i] = (i < R) ? 1 : 0;
      acc[i] = box[i];
    end
    for (int s = 0; s < 3; s++) begin
      longint tmp [NT];
      for (int i = 0; i < NT; i++) begin
        tmp[i] = 0;
        for (int k = 0; k <= i; k++) tmp[i] += acc[k] * box[i - k];
      end
      for (int i = 0; i < NT; i++) acc[i] = tmp[i];
    end
    for (int i = 0; i < NT; i++) taps[i] = acc[i];
  endfunction

  function automatic logic [23:0] exp_scale(input longint y);
    longint v;
    int sh;
    sh = 23 - MAG;
    if (sh >= 0) v = y <<< sh;
    else         v = y >>> (-sh);
    if (v > 64'sd8388607)  v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return v[23:0];
  endfunction

  function automatic void clear_model();
    for (int i = 0; i < NT; i++) hist[i] = 0;
    m_cnt = 0;
    m_dec = 0;
  endfunction

  function automatic void model_step(input bit v, input bit b, input bit s, input bit m);
    bit restart;
    longint y;
    exp_emit = 1'b0;
    restart = (int'(m) != m_mode) || (!m && s);
    if (restart) begin
      clear_model();
      m_active = (!m && s) ? 1 : 0;
    end
    m_mode = int'(m);
    if (v && (m || m_active != 0)) begin
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i - 1];
      hist[0] = b ? 1 : -1;
      m_cnt++;
      if (m_cnt == R) begin
        m_cnt = 0;
        m_dec++;
        if (m_dec >= 4) begin
          y = 0;
          for (int k = 0; k < NT; k++) y += taps[k] * hist[k];
          exp_emit = 1'b1;
          exp_val  = exp_scale(y);
          if (!m) begin
            clear_model();
            m_active = 0;
          end
        end
      end
    end
  endfunction

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit b, input bit s, input bit m);
    bit_valid = v;
    bit_in    = b;
    start     = s;
    mode_cont = m;
    model_step(v, b, s, m);
    @(posedge clk);
    @(negedge clk);
    check_bit(cur_tag, "out_valid", out_valid, exp_emit);
    if (exp_emit) begin
      check_word(cur_tag, "out_data", out_data, exp_val);
      last_d = exp_val;
    end else begin
      check_word("R11", "held out_data", out_data, last_d);
    end
  endtask

  task automatic single_conv(input int dens);
    drive(1'b1, 1'($urandom), 1'b1, 1'b0);
    while (m_active != 0)
      drive(($urandom % 100) < dens, 1'($urandom), 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd7051));
    build_taps();
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R1";
    check_bit("R1", "reset out_valid", out_valid, 1'b0);
    check_word("R1", "reset out_data", out_data, 24'h000000);

    cur_tag = "R2";
    for (int i = 0; i < 6 * R; i++) drive(1'b1, 1'b1, 1'b0, 1'b1);
    check_word("R2", "all ones", out_data, 24'h7FFFFF);
    for (int i = 0; i < 6 * R; i++) drive(1'b1, 1'b0, 1'b0, 1'b1);
    check_word("R2", "all zeros", out_data, 24'h800000);

    cur_tag = "R3";
    for (int i = 0; i < 6 * R; i++) drive(1'b1, 1'(i % 2 == 0), 1'b0, 1'b1);
    check_word("R3", "alternating", out_data, 24'h000000);

    cur_tag = "R12";
    for (int i = 0; i < 400; i++) drive(1'($urandom), 1'($urandom), 1'b0, 1'b1);

    cur_tag = "R8";
    for (int i = 0; i < 300; i++) drive(($urandom % 4) != 0, 1'($urandom), ($urandom % 8) == 0, 1'b1);

    cur_tag = "R4";
    for (int i = 0; i < 300; i++) drive(1'b1, ($urandom % 4) != 0, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) drive(1'b1, ($urandom % 4) == 0, 1'b0, 1'b1);

    cur_tag = "R10";
    for (int i = 0; i < 3 * R; i++) drive(1'b1, 1'($urandom), 1'b0, 1'b0);

    cur_tag = "R5";
    for (int c = 0; c < 5; c++) begin
      single_conv(70);
      cur_tag = "R6";
      for (int i = 0; i < 2 * R; i++) drive(1'($urandom), 1'($urandom), 1'b0, 1'b0);
      cur_tag = "R5";
    end

    cur_tag = "R9";
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 2 * R; i++) drive(1'b1, 1'($urandom), 1'b0, 1'b0);
    single_conv(100);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4 * R - 2; i++) drive(1'b1, 1'($urandom), 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check_bit("R9", "strobe at clash", out_valid, 1'b0);
    while (m_active != 0) drive(1'b1, 1'($urandom), 1'b0, 1'b0);

    cur_tag = "R10";
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 2 * R; i++) drive(1'b1, 1'($urandom), 1'b0, 1'b0);
    for (int i = 0; i < 5 * R; i++) drive(1'b1, 1'($urandom), 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6 * R; i++) drive(1'b1, 1'b1, 1'b0, 1'b1);
    check_word("R10", "restart after mode flip", out_data, 24'h7FFFFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule